// File: doc/BRIEF.md
# Compressed Instruction Expander

This block takes one 16-bit compressed halfword from the 32-bit base integer set's compressed extension and produces the equivalent full-width 32-bit instruction. A later decode stage then sees one instruction format only. Each result carries two flags. The illegal flag marks encodings that are reserved or carry a forbidden operand, and the halt flag marks the compressed jump-to-self.

Halfwords arrive on a valid/ready input. Results leave on a valid/ready output. By default a single register stage sits between the two. Its input is ready whenever that stage is empty or is being drained in the same cycle. A parameter can replace the stage with a purely combinational path.

Compressed register fields that are 3 bits wide name the registers x8 to x15, found by adding 8 to the field. A halfword whose two low bits are both set is not compressed. It is handed through zero-extended, with both flags clear.

Top module: `cx_expander`

## Requirements
- R1: The all-zero halfword is illegal. So is any add-to-stack-pointer-into-register form (low bits 00, bits 15:13 = 000) whose scaled immediate is zero. Whenever the illegal flag is set, the instruction output is zero.
- R2: A 3-bit compressed register field (bits 4:2 or 9:7) selects register number field+8 in the expanded instruction.
- R3: For quadrant 0, immediates are assembled as follows. In the stack-relative add, bits 12:11 go to imm[5:4], bits 10:7 to imm[9:6], bit 6 to imm[2] and bit 5 to imm[3]; it expands to ADDI rd', x2, imm. In the word load and word store, bits 12:10 go to offset[5:3], bit 6 to offset[2] and bit 5 to offset[6]; they expand to LW and SW.
- R4: In quadrant 1 with bits 15:13 = 011 and destination 2, the halfword is the stack-pointer adjust: ADDI x2, x2, imm. Its sign-extended immediate takes bit 9 from bit 12, bit 4 from bit 6, bit 6 from bit 5, bits 8:7 from bits 4:3 and bit 5 from bit 2. Any other destination gives LUI with imm[17] taken from bit 12 as the sign and imm[16:12] from bits 6:2. This LUI form is illegal when the destination is 0 or the immediate is 0.
- R5: Load-immediate (quadrant 1, 010) with destination 0 is illegal. Shift-left (quadrant 2, 000) with destination 0 is also illegal.
- R6: The three immediate shifts use bits 6:2 as the shift amount. If bit 12 is set, the halfword is illegal.
- R7: In quadrant 2 with bits 15:12 = 1001: both register fields zero gives EBREAK (0x00100073); rs2 zero with rs1 nonzero gives JALR x1, 0(rs1); anything else gives ADD rd, rd, rs2.
- R8: In quadrant 2 with bits 15:12 = 1000: rs2 zero gives JALR x0, 0(rs1), which is illegal when rs1 is 0; otherwise the result is ADD rd, x0, rs2.
- R9: The zero-test branches give BEQ or BNE rs1', x0, off. The sign-extended offset takes bit 8 from bit 12, bits 4:3 from bits 11:10, bits 7:6 from bits 6:5, bits 2:1 from bits 4:3 and bit 5 from bit 2. The compressed jumps give JAL with x1 (bits 15:13 = 001) or x0 (bits 15:13 = 101) as the link register.
- R10: The halt flag is set only for halfword 0xA001. That halfword expands legally to 0x0000006F.
- R11: An input with bits 1:0 = 11 is output as {16'h0, halfword}, with both flags clear.
- R12: Every remaining reserved encoding is illegal with a zero instruction. This covers quadrant 0 bits 15:13 other than 000, 010 and 110; quadrant 2 bits 15:13 of 001, 011, 101 and 111; and quadrant 1 with bits 15:10 = 100111.
- R13: After reset the output is not valid and the input is ready. While the output is valid and not accepted, the input is not ready and all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Halfword offered |
| in_ready | output | 1 | Halfword accepted this cycle when valid |
| in_half | input | HALF_W (16) | Compressed halfword |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_instr | output | WORD_W (32) | Expanded instruction |
| out_illegal | output | 1 | Illegal or reserved encoding |
| out_halt | output | 1 | Jump-to-self halfword seen |

## Verification
The bench builds the block with its default widths (16 in, 32 out) and the registered output stage switched on. This choice makes the stall and hold behaviour of R13 observable, including back-to-back acceptance while the stage drains. Random halfwords are biased toward the three compressed quadrants and run under both a free-flowing consumer and a randomly stalling one. A bench model computes every expected result arithmetically and compares against it. Directed halfwords pin down each precedence case, each forbidden operand and the jump-to-self against hand-computed constants.

// File: rtl/cx_pkg.sv
package cx_pkg;
   localparam int EXP_W = 32;
   localparam int CHW   = 16;

   localparam logic [6:0] OPC_IMM    = 7'b0010011;
   localparam logic [6:0] OPC_REG    = 7'b0110011;
   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_STORE  = 7'b0100011;
   localparam logic [6:0] OPC_LUI    = 7'b0110111;
   localparam logic [6:0] OPC_JAL    = 7'b1101111;
   localparam logic [6:0] OPC_JALR   = 7'b1100111;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;
   localparam logic [31:0] BREAK_WORD = 32'h0010_0073;

   localparam logic [4:0] REG_ZERO = 5'd0;
   localparam logic [4:0] REG_LINK = 5'd1;
   localparam logic [4:0] REG_SP   = 5'd2;

   typedef struct packed {
      logic [EXP_W-1:0] instr;
      logic             illegal;
   } cx_result_t;

   function automatic logic [31:0] mk_i(input logic [11:0] imm, input logic [4:0] rs1,
                                        input logic [2:0] f3, input logic [4:0] rd,
                                        input logic [6:0] op);
      return {imm, rs1, f3, rd, op};
   endfunction

   function automatic logic [31:0] mk_r(input logic [6:0] f7, input logic [4:0] rs2,
                                        input logic [4:0] rs1, input logic [2:0] f3,
                                        input logic [4:0] rd);
      return {f7, rs2, rs1, f3, rd, OPC_REG};
   endfunction

   function automatic logic [31:0] mk_s(input logic [11:0] imm, input logic [4:0] rs2,
                                        input logic [4:0] rs1);
      return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], OPC_STORE};
   endfunction

   function automatic logic [31:0] mk_b(input logic [12:0] imm, input logic [4:0] rs1,
                                        input logic [2:0] f3);
      return {imm[12], imm[10:5], REG_ZERO, rs1, f3, imm[4:1], imm[11], OPC_BRANCH};
   endfunction

   function automatic logic [31:0] mk_j(input logic [20:0] imm, input logic [4:0] rd);
      return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL};
   endfunction

   function automatic logic [4:0] short_reg(input logic [2:0] f);
      return {2'b01, f};
   endfunction
endpackage

// File: rtl/cx_quad0.sv
module cx_quad0 import cx_pkg::*; (
   input  logic [CHW-1:0] half_i,
   output cx_result_t     res_o
);
   logic [9:0] spn_imm;
   logic [6:0] word_off;
   logic [4:0] rd_c, rs1_c;
   logic       unused_q0;

   assign unused_q0 = ^half_i[1:0];
   assign spn_imm   = {half_i[10:7], half_i[12:11], half_i[5], half_i[6], 2'b00};
   assign word_off  = {half_i[5], half_i[12:10], half_i[6], 2'b00};
   assign rd_c      = short_reg(half_i[4:2]);
   assign rs1_c     = short_reg(half_i[9:7]);

   always_comb begin
      res_o = '0;
      unique case (half_i[15:13])
         3'b000: begin
            res_o.illegal = (spn_imm == '0);
            res_o.instr   = mk_i({2'b00, spn_imm}, REG_SP, 3'b000, rd_c, OPC_IMM);
         end
         3'b010: res_o.instr = mk_i({5'b0, word_off}, rs1_c, 3'b010, rd_c, OPC_LOAD);
         3'b110: res_o.instr = mk_s({5'b0, word_off}, rd_c, rs1_c);
         default: res_o.illegal = 1'b1;
      endcase
      if (res_o.illegal) res_o.instr = '0;
      if (half_i == '0) begin
         assert_zero_half_R1: assert (res_o.illegal && res_o.instr == '0);
      end
   end
endmodule

// File: rtl/cx_quad1.sv
module cx_quad1 import cx_pkg::*; (
   input  logic [CHW-1:0] half_i,
   output cx_result_t     res_o
);
   logic [4:0]  rd;
   logic [4:0]  rp1, rp2;
   logic [5:0]  imm6;
   logic [11:0] imm12;
   logic [11:0] jmp_off;
   logic [8:0]  br_off;
   logic [9:0]  sp_off;
   logic        unused_q1;

   assign unused_q1 = ^half_i[1:0];
   assign rd      = half_i[11:7];
   assign rp1     = short_reg(half_i[9:7]);
   assign rp2     = short_reg(half_i[4:2]);
   assign imm6    = {half_i[12], half_i[6:2]};
   assign imm12   = {{6{half_i[12]}}, imm6};
   assign jmp_off = {half_i[12], half_i[8], half_i[10:9], half_i[6], half_i[7],
                     half_i[2], half_i[11], half_i[5:3], 1'b0};
   assign br_off  = {half_i[12], half_i[6:5], half_i[2], half_i[11:10], half_i[4:3], 1'b0};
   assign sp_off  = {half_i[12], half_i[4:3], half_i[5], half_i[2], half_i[6], 4'b0000};

   always_comb begin
      res_o = '0;
      unique case (half_i[15:13])
         3'b000: res_o.instr = mk_i(imm12, rd, 3'b000, rd, OPC_IMM);
         3'b001: res_o.instr = mk_j({{9{half_i[12]}}, jmp_off}, REG_LINK);
         3'b010: begin
            res_o.illegal = (rd == REG_ZERO);
            res_o.instr   = mk_i(imm12, REG_ZERO, 3'b000, rd, OPC_IMM);
         end
         3'b011: begin
            if (rd == REG_SP) begin
               res_o.instr = mk_i({{2{half_i[12]}}, sp_off}, REG_SP, 3'b000, REG_SP, OPC_IMM);
            end else begin
               res_o.illegal = (rd == REG_ZERO) || (imm6 == '0);
               res_o.instr   = {{14{half_i[12]}}, imm6, rd, OPC_LUI};
            end
         end
         3'b100: begin
            unique case (half_i[11:10])
               2'b00: begin
                  res_o.illegal = half_i[12];
                  res_o.instr   = mk_i({7'b0000000, half_i[6:2]}, rp1, 3'b101, rp1, OPC_IMM);
               end
               2'b01: begin
                  res_o.illegal = half_i[12];
                  res_o.instr   = mk_i({7'b0100000, half_i[6:2]}, rp1, 3'b101, rp1, OPC_IMM);
               end
               2'b10: res_o.instr = mk_i(imm12, rp1, 3'b111, rp1, OPC_IMM);
               default: begin
                  res_o.illegal = half_i[12];
                  unique case (half_i[6:5])
                     2'b00:   res_o.instr = mk_r(7'b0100000, rp2, rp1, 3'b000, rp1);
                     2'b01:   res_o.instr = mk_r(7'b0000000, rp2, rp1, 3'b100, rp1);
                     2'b10:   res_o.instr = mk_r(7'b0000000, rp2, rp1, 3'b110, rp1);
                     default: res_o.instr = mk_r(7'b0000000, rp2, rp1, 3'b111, rp1);
                  endcase
               end
            endcase
         end
         3'b101: res_o.instr = mk_j({{9{half_i[12]}}, jmp_off}, REG_ZERO);
         3'b110: res_o.instr = mk_b({{4{half_i[12]}}, br_off}, rp1, 3'b000);
         default: res_o.instr = mk_b({{4{half_i[12]}}, br_off}, rp1, 3'b001);
      endcase
      if (res_o.illegal) res_o.instr = '0;
      if (half_i[15:13] == 3'b011 && rd == REG_SP) begin
         assert_sp_over_lui_R4: assert (!res_o.illegal && res_o.instr[6:0] == OPC_IMM);
      end
      if (half_i[15:13] == 3'b100 && half_i[11] == 1'b0 && half_i[12]) begin
         assert_shift_bit12_R6: assert (res_o.illegal);
      end
   end
endmodule

// File: rtl/cx_quad2.sv
module cx_quad2 import cx_pkg::*; (
   input  logic [CHW-1:0] half_i,
   output cx_result_t     res_o
);
   logic [4:0] rd, rs2;
   logic [7:0] lsp_off, ssp_off;
   logic       unused_q2;

   assign unused_q2 = ^half_i[1:0];
   assign rd      = half_i[11:7];
   assign rs2     = half_i[6:2];
   assign lsp_off = {half_i[3:2], half_i[12], half_i[6:4], 2'b00};
   assign ssp_off = {half_i[8:7], half_i[12:9], 2'b00};

   always_comb begin
      res_o = '0;
      unique case (half_i[15:13])
         3'b000: begin
            res_o.illegal = half_i[12] || (rd == REG_ZERO);
            res_o.instr   = mk_i({7'b0000000, rs2}, rd, 3'b001, rd, OPC_IMM);
         end
         3'b010: res_o.instr = mk_i({4'b0, lsp_off}, REG_SP, 3'b010, rd, OPC_LOAD);
         3'b100: begin
            if (!half_i[12]) begin
               if (rs2 == REG_ZERO) begin
                  res_o.illegal = (rd == REG_ZERO);
                  res_o.instr   = mk_i(12'h000, rd, 3'b000, REG_ZERO, OPC_JALR);
               end else begin
                  res_o.instr = mk_r(7'b0000000, rs2, REG_ZERO, 3'b000, rd);
               end
            end else if (rs2 == REG_ZERO && rd == REG_ZERO) begin
               res_o.instr = BREAK_WORD;
            end else if (rs2 == REG_ZERO) begin
               res_o.instr = mk_i(12'h000, rd, 3'b000, REG_LINK, OPC_JALR);
            end else begin
               res_o.instr = mk_r(7'b0000000, rs2, rd, 3'b000, rd);
            end
         end
         3'b110: res_o.instr = mk_s({4'b0, ssp_off}, rs2, REG_SP);
         default: res_o.illegal = 1'b1;
      endcase
      if (res_o.illegal) res_o.instr = '0;
      if (half_i[15:12] == 4'b1001 && rd == REG_ZERO && rs2 == REG_ZERO) begin
         assert_break_first_R7: assert (res_o.instr == BREAK_WORD);
      end
   end
endmodule

// File: rtl/cx_expander.sv
module cx_expander import cx_pkg::*; #(
   parameter int          HALF_W    = 16,
   parameter int          WORD_W    = 32,
   parameter bit          OUT_REG   = 1'b1,
   parameter logic [15:0] HALT_CODE = 16'hA001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [HALF_W-1:0] in_half,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_instr,
   output logic              out_illegal,
   output logic              out_halt
);
   localparam int PAD_W = WORD_W - HALF_W;

   if (HALF_W != CHW) begin : g_bad_half
      $error("cx_expander: HALF_W must equal %0d", CHW);
   end
   if (WORD_W != EXP_W) begin : g_bad_word
      $error("cx_expander: WORD_W must equal %0d", EXP_W);
   end

   cx_result_t res_q0, res_q1, res_q2, res_sel;
   logic       halt_c;

   cx_quad0 u_q0 (.half_i(in_half), .res_o(res_q0));
   cx_quad1 u_q1 (.half_i(in_half), .res_o(res_q1));
   cx_quad2 u_q2 (.half_i(in_half), .res_o(res_q2));

   always_comb begin
      unique case (in_half[1:0])
         2'b00:   res_sel = res_q0;
         2'b01:   res_sel = res_q1;
         2'b10:   res_sel = res_q2;
         default: res_sel = '{instr: {{PAD_W{1'b0}}, in_half}, illegal: 1'b0};
      endcase
   end
   assign halt_c = (in_half == HALT_CODE);

   if (OUT_REG) begin : g_reg
      logic              vld_r, ill_r, halt_r;
      logic [WORD_W-1:0] ins_r;

      assign in_ready = !vld_r || out_ready;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_r  <= 1'b0;
            ins_r  <= '0;
            ill_r  <= 1'b0;
            halt_r <= 1'b0;
         end else if (in_ready) begin
            vld_r <= in_valid;
            if (in_valid) begin
               ins_r  <= res_sel.instr;
               ill_r  <= res_sel.illegal;
               halt_r <= halt_c;
            end
         end
      end

      assign out_valid   = vld_r;
      assign out_instr   = ins_r;
      assign out_illegal = ill_r;
      assign out_halt    = halt_r;

      assert_hold_stall_R13: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid && !out_ready |=> out_valid && $stable(out_instr)
                                     && $stable(out_illegal) && $stable(out_halt));
      assert_ready_stall_R13: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid && !out_ready |-> !in_ready);
      assert_passthru_R11: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && in_ready && in_half[1:0] == 2'b11
         |=> out_valid && out_instr == {{PAD_W{1'b0}}, $past(in_half)} && !out_illegal);
   end else begin : g_comb
      assign in_ready    = out_ready;
      assign out_valid   = in_valid;
      assign out_instr   = res_sel.instr;
      assign out_illegal = res_sel.illegal;
      assign out_halt    = halt_c;
   end

   assert_halt_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_halt |-> !out_illegal && out_instr == 32'h0000_006F);
   assert_illegal_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_illegal |-> out_instr == '0);
endmodule

// File: tb/tb_cx_expander.sv
module tb_cx_expander;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_half = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_instr;
   logic        out_illegal;
   logic        out_halt;

   int total = 0;
   int fails = 0;
   logic [33:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   cx_expander dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_half(in_half), .out_valid(out_valid), .out_ready(out_ready),
      .out_instr(out_instr), .out_illegal(out_illegal), .out_halt(out_halt)
   );

   function automatic logic [31:0] ity(logic [31:0] imm, logic [31:0] rs1, logic [31:0] f3,
                                       logic [31:0] rd, logic [31:0] op);
      return {imm[11:0], rs1[4:0], f3[2:0], rd[4:0], op[6:0]};
   endfunction
   function automatic logic [31:0] rty(logic [31:0] f7, logic [31:0] rs2, logic [31:0] rs1,
                                       logic [31:0] f3, logic [31:0] rd);
      return {f7[6:0], rs2[4:0], rs1[4:0], f3[2:0], rd[4:0], 7'h33};
   endfunction
   function automatic logic [31:0] sty(logic [31:0] imm, logic [31:0] rs2, logic [31:0] rs1);
      return {imm[11:5], rs2[4:0], rs1[4:0], 3'b010, imm[4:0], 7'h23};
   endfunction
   function automatic logic [31:0] bty(logic [31:0] imm, logic [31:0] rs1, logic [31:0] f3);
      return {imm[12], imm[10:5], 5'd0, rs1[4:0], f3[2:0], imm[4:1], imm[11], 7'h63};
   endfunction
   function automatic logic [31:0] jty(logic [31:0] imm, logic [31:0] rd);
      return {imm[20], imm[10:1], imm[11], imm[19:12], rd[4:0], 7'h6F};
   endfunction

   // {halt, illegal, instr}, built from the requirement text
   function automatic logic [33:0] ref_expand(logic [15:0] h);
      logic [31:0] ins;
      logic        ill;
      int          f, rd, rs2, c1, c2, s6, off;
      ins = '0; ill = 1'b0;
      f = int'(h[15:13]); rd = int'(h[11:7]); rs2 = int'(h[6:2]);
      c1 = int'(h[9:7]) + 8; c2 = int'(h[4:2]) + 8;
      s6 = h[12] ? int'(h[6:2]) - 32 : int'(h[6:2]);
      if (h[1:0] == 2'b11) begin
         ins = {16'h0, h};
      end else if (h[1:0] == 2'b00) begin
         if (f == 0) begin
            off = int'(h[12:11]) * 16 + int'(h[10:7]) * 64 + int'(h[6]) * 4 + int'(h[5]) * 8;
            ill = (off == 0);
            ins = ity(off, 2, 0, c2, 32'h13);
         end else if (f == 2 || f == 6) begin
            off = int'(h[5]) * 64 + int'(h[12:10]) * 8 + int'(h[6]) * 4;
            ins = (f == 2) ? ity(off, c1, 2, c2, 32'h03) : sty(off, c2, c1);
         end else ill = 1'b1;
      end else if (h[1:0] == 2'b01) begin
         case (f)
            0: ins = ity(s6, rd, 0, rd, 32'h13);
            1, 5: begin
               off = (h[12] ? -2048 : 0) + int'(h[8]) * 1024 + int'(h[10:9]) * 256 +
                     int'(h[6]) * 128 + int'(h[7]) * 64 + int'(h[2]) * 32 +
                     int'(h[11]) * 16 + int'(h[5:3]) * 2;
               ins = jty(off, (f == 1) ? 1 : 0);
            end
            2: begin ill = (rd == 0); ins = ity(s6, 0, 0, rd, 32'h13); end
            3: begin
               if (rd == 2) begin
                  off = (h[12] ? -512 : 0) + int'(h[4:3]) * 128 + int'(h[5]) * 64 +
                        int'(h[2]) * 32 + int'(h[6]) * 16;
                  ins = ity(off, 2, 0, 2, 32'h13);
               end else begin
                  ill = (rd == 0) || (s6 == 0);
                  off = s6 * 4096;
                  ins = {off[31:12], rd[4:0], 7'h37};
               end
            end
            4: begin
               case (h[11:10])
                  2'b00: begin ill = h[12]; ins = ity(rs2, c1, 5, c1, 32'h13); end
                  2'b01: begin ill = h[12]; ins = ity(rs2 + 1024, c1, 5, c1, 32'h13); end
                  2'b10: ins = ity(s6, c1, 7, c1, 32'h13);
                  default: begin
                     ill = h[12];
                     case (h[6:5])
                        2'b00: ins = rty(32, c2, c1, 0, c1);
                        2'b01: ins = rty(0, c2, c1, 4, c1);
                        2'b10: ins = rty(0, c2, c1, 6, c1);
                        default: ins = rty(0, c2, c1, 7, c1);
                     endcase
                  end
               endcase
            end
            default: begin
               off = (h[12] ? -256 : 0) + int'(h[6:5]) * 64 + int'(h[2]) * 32 +
                     int'(h[11:10]) * 8 + int'(h[4:3]) * 2;
               ins = bty(off, c1, (f == 6) ? 0 : 1);
            end
         endcase
      end else begin
         case (f)
            0: begin ill = h[12] || rd == 0; ins = ity(rs2, rd, 1, rd, 32'h13); end
            2: begin
               off = int'(h[3:2]) * 64 + int'(h[12]) * 32 + int'(h[6:4]) * 4;
               ins = ity(off, 2, 2, rd, 32'h03);
            end
            4: begin
               if (!h[12]) begin
                  if (rs2 == 0) begin ill = (rd == 0); ins = ity(0, rd, 0, 0, 32'h67); end
                  else ins = rty(0, rs2, 0, 0, rd);
               end else if (rs2 == 0 && rd == 0) ins = 32'h0010_0073;
               else if (rs2 == 0) ins = ity(0, rd, 0, 1, 32'h67);
               else ins = rty(0, rs2, rd, 0, rd);
            end
            6: begin
               off = int'(h[8:7]) * 64 + int'(h[12:9]) * 4;
               ins = sty(off, rs2, 2);
            end
            default: ill = 1'b1;
         endcase
      end
      if (ill) ins = '0;
      return {(h == 16'hA001), ill, ins};
   endfunction

   task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got halt=%0b ill=%0b instr=%h, expected halt=%0b ill=%0b instr=%h",
                  tag, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
      end
   endtask

   task automatic direct(input logic [15:0] h, input logic [31:0] ei, input logic eill,
                         input logic ehalt, input string tag);
      @(negedge clk);
      in_valid = 1'b1; in_half = h; out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      #1;
      check(tag, {out_halt, out_illegal, out_instr}, {ehalt, eill, ei});
   endtask

   function automatic logic [15:0] gen_half();
      logic [31:0] r;
      logic [15:0] h;
      r = $urandom;
      h = r[15:0];
      if (r[16]) h[1:0] = (r[18:17] == 2'b11) ? 2'b00 : r[18:17];
      if (r[20:19] == 2'b00) h[11:7] = 5'd0;
      if (r[22:21] == 2'b00) h[6:2] = 5'd0;
      return h;
   endfunction

   function automatic string quad_tag(logic [15:0] h);
      case (h[1:0])
         2'b00: return "R3 quadrant0";
         2'b01: return "R9 quadrant1";
         2'b10: return "R7 quadrant2";
         default: return "R11 uncompressed";
      endcase
   endfunction

   task automatic finish_run();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog: run did not complete, got timeout, expected completion");
      finish_run();
   end

   initial begin
      int unsigned seed_v;
      seed_v = $urandom(32'd7341);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check("R13 reset state", {1'b0, out_valid, 31'b0, in_ready}, {1'b0, 1'b0, 31'b0, 1'b1});

      direct(16'h0000, 32'h0, 1'b1, 1'b0, "R1 zero halfword");
      direct(16'h0004, 32'h0, 1'b1, 1'b0, "R1 zero stack immediate");
      direct(16'h0040, 32'h0041_0413, 1'b0, 1'b0, "R3 R2 stack add into x8");
      direct(16'h6141, 32'h0101_0113, 1'b0, 1'b0, "R4 sp adjust over upper imm");
      direct(16'h6005, 32'h0, 1'b1, 1'b0, "R4 upper imm dest zero");
      direct(16'h6085, 32'h0000_10B7, 1'b0, 1'b0, "R4 upper imm legal");
      direct(16'h4001, 32'h0, 1'b1, 1'b0, "R5 load-imm dest zero");
      direct(16'h4081, 32'h0000_0093, 1'b0, 1'b0, "R5 load-imm legal");
      direct(16'h0006, 32'h0, 1'b1, 1'b0, "R5 shift-left dest zero");
      direct(16'h9001, 32'h0, 1'b1, 1'b0, "R6 shift bit12 set");
      direct(16'h8005, 32'h0014_5413, 1'b0, 1'b0, "R6 R2 right shift x8");
      direct(16'h9002, 32'h0010_0073, 1'b0, 1'b0, "R7 break");
      direct(16'h9082, 32'h0000_80E7, 1'b0, 1'b0, "R7 link jump");
      direct(16'h908A, 32'h0020_80B3, 1'b0, 1'b0, "R7 add");
      direct(16'h808A, 32'h0020_00B3, 1'b0, 1'b0, "R8 move");
      direct(16'h8002, 32'h0, 1'b1, 1'b0, "R8 jump via x0");
      direct(16'h8082, 32'h0000_8067, 1'b0, 1'b0, "R8 register jump");
      direct(16'hC009, 32'h0004_0163, 1'b0, 1'b0, "R9 branch-if-zero +2");
      direct(16'hFC7D, 32'hFE04_1FE3, 1'b0, 1'b0, "R9 branch-if-nonzero -2");
      direct(16'hA001, 32'h0000_006F, 1'b0, 1'b1, "R10 jump to self");
      direct(16'h2001, 32'h0000_00EF, 1'b0, 1'b0, "R10 R9 linked jump no halt");
      direct(16'h0013, 32'h0000_0013, 1'b0, 1'b0, "R11 pass through");
      direct(16'h2000, 32'h0, 1'b1, 1'b0, "R12 quadrant0 reserved");
      direct(16'h9C01, 32'h0, 1'b1, 1'b0, "R12 quadrant1 reserved");
      direct(16'h2002, 32'h0, 1'b1, 1'b0, "R12 quadrant2 reserved");

      // R13 back-pressure
      @(negedge clk);
      out_ready = 1'b0; in_valid = 1'b1; in_half = 16'h4081;
      @(negedge clk);
      in_half = 16'h808A; #1;
      check("R13 not ready while stalled", {33'b0, in_ready}, 34'b0);
      check("R13 stalled output", {out_halt, out_illegal, out_instr}, {2'b00, 32'h0000_0093});
      @(negedge clk); #1;
      check("R13 output held", {out_halt, out_illegal, out_instr}, {2'b00, 32'h0000_0093});
      @(negedge clk);
      out_ready = 1'b1; #1;
      check("R13 ready on drain", {33'b0, in_ready}, {33'b0, 1'b1});
      @(negedge clk);
      in_valid = 1'b0; #1;
      check("R13 next item", {out_halt, out_illegal, out_instr}, {2'b00, 32'h0020_00B3});

      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         in_valid  = ($urandom % 4) != 0;
         out_ready = (c < 2000) ? 1'b1 : (($urandom % 4) != 0);
         in_half   = gen_half();
         #1;
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               check("R13 unexpected output", {1'b0, out_valid, 32'b0}, 34'b0);
            end else begin
               check(tag_q.pop_front(), {out_halt, out_illegal, out_instr}, exp_q.pop_front());
            end
         end
         if (in_valid && in_ready) begin
            exp_q.push_back(ref_expand(in_half));
            tag_q.push_back(quad_tag(in_half));
         end
      end
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b1; #1;
      while (exp_q.size() != 0) begin
         if (out_valid) check(tag_q.pop_front(), {out_halt, out_illegal, out_instr}, exp_q.pop_front());
         else begin
            check("R13 missing output", {1'b0, out_valid, 32'b0}, {1'b0, 1'b1, 32'b0});
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
         end
         @(negedge clk); #1;
      end
      finish_run();
   end
endmodule